// File: doc/BRIEF.md
# Program Counter and Control-Flow Sequencer

This block owns the program counter of a 16-bit, byte-addressed processor whose instructions are all two bytes wide. In every cycle it is given the instruction fetched at the current PC, the three condition flags and the present value of the link register (register 13). From these it chooses the next PC. The choices are: step to the following instruction, take a PC-relative branch when a flag condition is true, jump to an absolute target inside the current 4 KB page (a call), or return to the address held in the link register. When a call is seen, the block also raises a one-cycle write request so that the register file stores the return address in register 13.

The decision is a four-way flow selection: `FLOW_SEQ`, `FLOW_BRANCH`, `FLOW_CALL` and `FLOW_RET`. It is made by a `unique case` on the opcode, and the branch condition evaluator qualifies that case. A two-state run controller sits around the flow selection. The controller is in `PCU_HALT` while reset is sampled high, and it moves from `PCU_HALT` or `PCU_RUN` to `PCU_HALT` whenever reset is high. It moves from `PCU_HALT` to `PCU_RUN`, and stays in `PCU_RUN`, on each edge where reset is low. The PC register changes only on those edges.

Top module: `pc_seq_unit`

## Requirements
- R1: An edge with `rst` high loads 0x0000 into the PC. While `rst` is high, `link_we_o` stays low, even when a call instruction is presented.
- R2: Opcodes 0000 through 1100 (bits [15:12]) advance the PC by 2 on the next edge, whatever the flags and link inputs are.
- R3: A branch is opcode 1101, with the condition in bits [10:8] and a signed byte offset in bits [7:0]. With flags_i[2]=Z, flags_i[1]=V and flags_i[0]=N, the branch is taken on: 000 Z; 001 N&!V; 010 !Z&!N&!V; 011 V; 100 !Z; 101 !(N&!V); 110 (N&!V)|Z; 111 always.
- R4: A taken branch sets the PC to (PC+2) + 2*sext(bits[7:0]). A branch that is not taken sets the PC to PC+2. Bit 11 of a branch has no effect.
- R5: A call (opcode 1110) sets the PC to {(PC+2)[15:12], instr[11:0]}.
- R6: In the cycle in which a call is presented and `rst` is low, `link_we_o` is 1, `link_idx_o` is 13 and `link_data_o` is PC+2. For every other opcode, `link_we_o` is 0.
- R7: A return (opcode 1111) sets the PC to `link_i`. Bits [11:0] of a return have no effect.
- R8: All PC arithmetic wraps modulo 2^16. PC+2 from 0xFFFE gives 0x0000, and branch targets wrap in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 16 | Instruction fetched at the current PC |
| flags_i | input | 3 | Condition flags {Z, V, N} |
| link_i | input | 16 | Current contents of register 13 |
| pc_o | output | 16 | Current program counter |
| link_we_o | output | 1 | Register-file write request for a call |
| link_idx_o | output | 4 | Register index of the link write (always 13) |
| link_data_o | output | 16 | Return address PC+2 for the link write |

## Verification
Every wrong choice of flow or target appears on `pc_o` at the very next edge, so a fault is visible one cycle after the instruction that exposes it. A condition decoded wrongly for one flag combination only shows when that exact combination meets that exact code. For this reason the bench sweeps all 64 pairs of condition code and flag value, using forward, backward and zero offsets. A stale or shifted link request shows in the same cycle on the three link outputs. The bench places calls on several pages and at the 0xFFFE boundary, where the page bits of PC+2 differ from those of the PC.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    // Opcode values in instruction bits [15:12]
    localparam logic [3:0] OPC_BRANCH = 4'b1101;
    localparam logic [3:0] OPC_CALL   = 4'b1110;
    localparam logic [3:0] OPC_RET    = 4'b1111;

    // Condition flags as carried on the flag bus, MSB first
    typedef struct packed {
        logic z;
        logic v;
        logic n;
    } flags_t;

    // Selected control-flow kind for the current instruction
    typedef enum logic [1:0] {
        FLOW_SEQ    = 2'd0,
        FLOW_BRANCH = 2'd1,
        FLOW_CALL   = 2'd2,
        FLOW_RET    = 2'd3
    } flow_e;

    // Run controller
    typedef enum logic {
        PCU_HALT = 1'b0,
        PCU_RUN  = 1'b1
    } pcu_state_e;

endpackage

// File: rtl/pcu_cond_eval.sv
module pcu_cond_eval
    import pcu_pkg::*;
#(
    parameter int COND_W = 3
) (
    input  logic [COND_W-1:0] cond_i,
    input  flags_t            flags_i,
    output logic              taken_o
);

    logic less;

    assign less = flags_i.n & ~flags_i.v;

    always_comb begin
        unique case (cond_i)
            3'b000:  taken_o = flags_i.z;
            3'b001:  taken_o = less;
            3'b010:  taken_o = ~flags_i.z & ~flags_i.n & ~flags_i.v;
            3'b011:  taken_o = flags_i.v;
            3'b100:  taken_o = ~flags_i.z;
            3'b101:  taken_o = ~less;
            3'b110:  taken_o = less | flags_i.z;
            3'b111:  taken_o = 1'b1;
            default: taken_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcu_target_gen.sv
module pcu_target_gen #(
    parameter int ADDR_W    = 16,
    parameter int OFF_W     = 8,
    parameter int PAGE_LO_W = 12,
    parameter int STEP      = 2
) (
    input  logic [ADDR_W-1:0]    pc_i,
    input  logic [OFF_W-1:0]     off_i,
    input  logic [PAGE_LO_W-1:0] page_lo_i,
    output logic [ADDR_W-1:0]    pc_inc_o,
    output logic [ADDR_W-1:0]    br_target_o,
    output logic [ADDR_W-1:0]    call_target_o
);

    localparam int EXT_W = ADDR_W - OFF_W - 1;

    logic [ADDR_W-1:0] disp;

    // Offset counts instructions: sign-extend, then scale by two
    assign disp          = {{EXT_W{off_i[OFF_W-1]}}, off_i, 1'b0};
    assign pc_inc_o      = pc_i + ADDR_W'(STEP);
    assign br_target_o   = pc_inc_o + disp;
    assign call_target_o = {pc_inc_o[ADDR_W-1:PAGE_LO_W], page_lo_i};

endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
    import pcu_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int INSTR_W   = 16,
    parameter int REG_IDX_W = 4,
    parameter int LINK_REG  = 13
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [INSTR_W-1:0]   instr_i,
    input  logic [2:0]           flags_i,
    input  logic [ADDR_W-1:0]    link_i,
    output logic [ADDR_W-1:0]    pc_o,
    output logic                 link_we_o,
    output logic [REG_IDX_W-1:0] link_idx_o,
    output logic [ADDR_W-1:0]    link_data_o
);

    localparam int OPC_W     = 4;
    localparam int OPC_LO    = INSTR_W - OPC_W;
    localparam int PAGE_LO_W = INSTR_W - OPC_W;
    localparam int OFF_W     = 8;
    localparam int COND_W    = 3;
    localparam int STEP      = INSTR_W / 8;
    localparam int EXT_W     = ADDR_W - OFF_W - 1;

    logic [OPC_W-1:0]  opcode;
    logic              br_taken;
    flow_e             flow;
    pcu_state_e        state_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_next;
    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] br_target;
    logic [ADDR_W-1:0] call_target;

    assign opcode = instr_i[INSTR_W-1:OPC_LO];

    pcu_cond_eval #(
        .COND_W (COND_W)
    ) u_cond (
        .cond_i  (instr_i[OFF_W+COND_W-1:OFF_W]),
        .flags_i (flags_t'(flags_i)),
        .taken_o (br_taken)
    );

    pcu_target_gen #(
        .ADDR_W    (ADDR_W),
        .OFF_W     (OFF_W),
        .PAGE_LO_W (PAGE_LO_W),
        .STEP      (STEP)
    ) u_tgt (
        .pc_i          (pc_q),
        .off_i         (instr_i[OFF_W-1:0]),
        .page_lo_i     (instr_i[PAGE_LO_W-1:0]),
        .pc_inc_o      (pc_inc),
        .br_target_o   (br_target),
        .call_target_o (call_target)
    );

    // Flow selection
    always_comb begin
        flow = FLOW_SEQ;
        unique case (opcode)
            OPC_BRANCH: flow = br_taken ? FLOW_BRANCH : FLOW_SEQ;
            OPC_CALL:   flow = FLOW_CALL;
            OPC_RET:    flow = FLOW_RET;
            default:    flow = FLOW_SEQ;
        endcase
    end

    always_comb begin
        unique case (flow)
            FLOW_SEQ:    pc_next = pc_inc;
            FLOW_BRANCH: pc_next = br_target;
            FLOW_CALL:   pc_next = call_target;
            FLOW_RET:    pc_next = link_i;
            default:     pc_next = pc_inc;
        endcase
    end

    // State register: run controller and PC
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PCU_HALT;
            pc_q    <= '0;
        end else begin
            state_q <= PCU_RUN;
            pc_q    <= pc_next;
        end
    end

    // Outputs
    always_comb begin
        pc_o        = pc_q;
        link_we_o   = (flow == FLOW_CALL) && !rst;
        link_idx_o  = REG_IDX_W'(LINK_REG);
        link_data_o = pc_inc;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> pc_o == '0);

    // R1
    reset_no_link_chk: assert property (@(posedge clk) rst |-> !link_we_o);

    // R1
    halt_pc_zero_chk: assert property (@(posedge clk) (state_q == PCU_HALT) |-> pc_o == '0);

    // R2
    seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (opcode != OPC_BRANCH && opcode != OPC_CALL && opcode != OPC_RET)
        |=> pc_o == $past(pc_o) + ADDR_W'(STEP));

    // R4
    always_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (opcode == OPC_BRANCH && instr_i[OFF_W+COND_W-1:OFF_W] == 3'b111)
        |=> pc_o == $past(pc_o) + ADDR_W'(STEP)
                  + {{EXT_W{$past(instr_i[OFF_W-1])}}, $past(instr_i[OFF_W-1:0]), 1'b0});

    // R5
    call_splice_chk: assert property (@(posedge clk) disable iff (rst)
        link_we_o |=> pc_o == {$past(link_data_o[ADDR_W-1:PAGE_LO_W]),
                               $past(instr_i[PAGE_LO_W-1:0])});

    // R7
    ret_load_chk: assert property (@(posedge clk) disable iff (rst)
        (opcode == OPC_RET) |=> pc_o == $past(link_i));

endmodule

// File: tb/pc_seq_unit_bench.sv
`timescale 1ns/1ps
module pc_seq_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr = 16'h0000;
    logic [2:0]  flags = 3'b000;
    logic [15:0] link = 16'h0000;
    logic [15:0] pc_o;
    logic        link_we_o;
    logic [3:0]  link_idx_o;
    logic [15:0] link_data_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_pc = 16'h0000;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pc_seq_unit u_pc_seq_unit (
        .clk         (clk),
        .rst         (rst),
        .instr_i     (instr),
        .flags_i     (flags),
        .link_i      (link),
        .pc_o        (pc_o),
        .link_we_o   (link_we_o),
        .link_idx_o  (link_idx_o),
        .link_data_o (link_data_o)
    );

    task automatic chk(input string tag, input bit ok, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    function automatic bit cond_model(input logic [2:0] c, input logic [2:0] f);
        bit z, v, n, lt;
        z = f[2]; v = f[1]; n = f[0];
        lt = n && !v;
        case (c)
            3'd0: return z;
            3'd1: return lt;
            3'd2: return !z && !n && !v;
            3'd3: return v;
            3'd4: return !z;
            3'd5: return !lt;
            3'd6: return lt || z;
            default: return 1'b1;
        endcase
    endfunction

    // One instruction cycle: drive away from the edge, check link outputs,
    // then check the PC after the edge.
    task automatic step(input logic r, input logic [15:0] ins, input logic [2:0] fl,
                        input logic [15:0] lk, input string tag);
        logic [15:0] inc, nxt;
        logic [3:0] op;
        logic exp_we;
        @(negedge clk);
        rst = r; instr = ins; flags = fl; link = lk;
        #1;
        op = ins[15:12];
        inc = exp_pc + 16'd2;
        exp_we = (op == 4'hE) && !r;
        if (r) chk("R1 link quiet in reset", link_we_o == 1'b0, 16'(link_we_o), 16'd0);
        else   chk("R6 link_we", link_we_o == exp_we, 16'(link_we_o), 16'(exp_we));
        if (exp_we) begin
            chk("R6 link_idx", link_idx_o == 4'd13, 16'(link_idx_o), 16'd13);
            chk("R6 link_data", link_data_o == inc, link_data_o, inc);
        end
        if (r) nxt = 16'h0000;
        else begin
            case (op)
                4'hD: nxt = cond_model(ins[10:8], fl)
                            ? inc + {{7{ins[7]}}, ins[7:0], 1'b0} : inc;
                4'hE: nxt = {inc[15:12], ins[11:0]};
                4'hF: nxt = lk;
                default: nxt = inc;
            endcase
        end
        @(posedge clk);
        #1;
        chk(tag, pc_o == nxt, pc_o, nxt);
        exp_pc = nxt;
    endtask

    initial begin
        // R1: reset state
        step(1'b1, 16'h0000, 3'b000, 16'h0000, "R1 reset clears pc");
        step(1'b1, 16'hE123, 3'b111, 16'h1234, "R1 reset with call");

        // R2: every non-control opcode advances by two
        for (int op = 0; op < 13; op++) begin
            for (int k = 0; k < 4; k++) begin
                step(1'b0, {4'(op), 12'(k * 12'h3A5 + op)}, 3'(k + op), 16'(k * 16'h1111),
                     "R2 sequential advance");
            end
        end

        // R3, R4: all conditions against all flag values, several offsets
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 8; f++) begin
                for (int o = 0; o < 5; o++) begin
                    logic [7:0] off;
                    case (o)
                        0: off = 8'h00;
                        1: off = 8'h7F;
                        2: off = 8'h80;
                        3: off = 8'h05;
                        default: off = 8'hFB;
                    endcase
                    step(1'b0, 16'hF000, 3'b000, 16'h4000 + 16'(c * 64 + f * 4), "R7 ret to base");
                    step(1'b0, {4'hD, 1'((c + f + o) % 2), 3'(c), off}, 3'(f), 16'hDEAD,
                         "R3 R4 branch");
                end
            end
        end

        // R5, R6: calls from several pages
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 16'hF5A5, 3'b000, 16'(i * 16'h2346), "R7 ret to call site");
            step(1'b0, {4'hE, 12'(i * 12'h135 ^ 12'hABC)}, 3'(i), 16'h0000, "R5 call target");
        end

        // R7: return ignores low instruction bits
        for (int i = 0; i < 16; i++) begin
            step(1'b0, {4'hF, 12'(i * 12'h111)}, 3'(i), 16'(i * 16'h1357 + 16'h0042),
                 "R7 ret loads link");
        end

        // R8: wraparound
        step(1'b0, 16'hF000, 3'b000, 16'hFFFE, "R7 ret to top");
        step(1'b0, 16'h0123, 3'b000, 16'h0000, "R8 sequential wrap");
        step(1'b0, 16'hF000, 3'b000, 16'hFFFE, "R7 ret to top");
        step(1'b0, 16'hE456, 3'b000, 16'h0000, "R8 call page from wrapped pc");
        step(1'b0, 16'hF000, 3'b000, 16'hFFF0, "R7 ret near top");
        step(1'b0, 16'hD77F, 3'b000, 16'h0000, "R8 forward branch wrap");
        step(1'b0, 16'hF000, 3'b000, 16'h0004, "R7 ret near bottom");
        step(1'b0, 16'hDF80, 3'b000, 16'h0000, "R8 backward branch wrap");

        // R1: reset mid-run while a call is presented
        step(1'b0, 16'hF000, 3'b000, 16'h8888, "R7 ret before reset");
        step(1'b1, 16'hEFFF, 3'b000, 16'h0000, "R1 reset mid-run");
        step(1'b0, 16'h0000, 3'b000, 16'h0000, "R2 advance after reset");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule